// File: doc/BRIEF.md
# Multi-pipe buffer swap synchronizer

This controller lets one graphics pipe swap its display buffers in lockstep with other pipes. All pipes share one open-drain ready line. Each pipe releases the line when it has finished drawing, so the line reads high only once every pipe is ready. The controller drives this pipe's contribution and samples the resolved line through a two-flop synchronizer. At each decision point (the vertical-blank start pulse) it grants a swap only if the local pipe is ready and the line shows every pipe ready. If the line is not ready, the local readiness is held and the decision is tried again at the next pulse.

Small skew between pipes could let one pipe see a ready change that another pipe misses. To prevent this, a programmable number of clocks before each decision point forms an exclusion window. A swap request that arrives inside the window is parked and takes effect only after the window closes, so the shared line stays stable while every pipe samples it.

The block also handles the resize (magnification) and video-request settings of up to eight display channels. The channel index is the display ID. Each channel holds a staged copy and an active copy of its settings. A write lands in the staged copy. The staged values become active only at that channel's own next swap event, which is its first vertical blank after a grant. A channel whose frame overruns therefore keeps its old settings.

Top module: `swap_lockstep_ctrl`

## Requirements
- R1: After reset, `swap_grant`, `rdy_release` and every bit of `chan_swap` are 0, and all active magnification and request values are 0.
- R2: A `swap_req` pulse in a cycle where `cyc_to_dec >= win_len` and `dec_pulse` is low sets `rdy_release` to 1 at the next clock edge.
- R3: A `swap_req` in a cycle where `cyc_to_dec < win_len` does not change `rdy_release` while the window lasts. The request is parked, and `rdy_release` rises at the first edge of a cycle that is outside the window and has no decision pulse.
- R4: `swap_grant` is a one-cycle pulse that follows a cycle with `dec_pulse` high, but only if `rdy_release` was 1 and the shared line, seen through two synchronizer flops, was high.
- R5: If the line is low at a decision point, no grant is issued, `rdy_release` stays at 1, and the swap is granted at a later decision point once the line is high.
- R6: A grant returns `rdy_release` to 0 in the same edge.
- R7: `swap_grant` is never high in a cycle that does not directly follow a `dec_pulse`, and it never lasts two cycles.
- R8: A write (`wr_en`, `wr_id`, `wr_mag`, `wr_vreq`) changes only the staged copy of channel `wr_id`. The active outputs are unchanged until that channel swaps.
- R9: After a grant, the first `chan_vblank[i]` pulse raises `chan_swap[i]` for one cycle. In the same edge the staged values of channel i become active at `act_mag[i*MAG_W +: MAG_W]` and `act_vreq[i*VRQ_W +: VRQ_W]`.
- R10: A `chan_vblank[i]` pulse with no grant since channel i's last swap raises no `chan_swap[i]` and leaves its active values unchanged.
- R11: A channel that swaps with no pending write keeps its active values, and a swap on one channel leaves the other channels' active values untouched.
- R12: If a write to channel i coincides with its swap, the previously staged values become active, and the new write stays staged for the next swap.
- R13: With `win_len` = 0 there is no exclusion window, and a request three cycles before the decision point is still granted at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_req | input | 1 | One-cycle pulse: local drawing finished, swap wanted |
| cyc_to_dec | input | CNT_W | Clocks remaining until the next decision point |
| win_len | input | CNT_W | Exclusion window length in clocks before the decision point |
| dec_pulse | input | 1 | Vertical-blank start pulse (decision point) |
| rdy_release | output | 1 | 1 releases the shared line (ready), 0 pulls it low |
| line_in | input | 1 | Resolved shared ready line, asynchronous |
| swap_grant | output | 1 | One-cycle pulse: buffer swap granted |
| wr_en | input | 1 | Staged-settings write strobe |
| wr_id | input | ID_W | Display ID (channel index) of the write |
| wr_mag | input | MAG_W | Magnification value to stage |
| wr_vreq | input | VRQ_W | Video-request value to stage |
| chan_vblank | input | NCH | Per-channel vertical-blank pulses |
| chan_swap | output | NCH | Per-channel swap event pulses |
| act_mag | output | NCH*MAG_W | Active magnification values, channel i at bits i*MAG_W |
| act_vreq | output | NCH*VRQ_W | Active video-request values, channel i at bits i*VRQ_W |

## Verification
The consensus path is run through a series of frames.

- A request placed well before the window, with the other pipes ready, separates a correct grant from a missing one.
- The same request with another pipe holding the line low tests the hold-and-retry behaviour. The frame that follows shows the retry succeeding without a new request.
- A request inside the window tests that the ready register is truly blocked: it must not rise before the decision, and it must rise once the window closes.
- A late request with the window disabled tests both the zero-length case and the two-flop latency on the line.

The channel path is tested in four ways:

- Blank pulses without a grant show that staged settings stay inactive.
- Simultaneous blanks on a written and an unwritten channel show per-ID independence.
- A repeated blank shows that a swap is consumed.
- A write that coincides with a swap shows which copy wins.

// File: rtl/swap_sync_pkg.sv
package swap_sync_pkg;

  localparam int DEF_NCH   = 8;
  localparam int DEF_CNT_W = 12;
  localparam int DEF_MAG_W = 8;
  localparam int DEF_VRQ_W = 8;

  // exclusion test: the window covers the last win clocks before a decision
  function automatic logic in_excl_window(input logic [DEF_CNT_W-1:0] left,
                                          input logic [DEF_CNT_W-1:0] win);
    return left < win;
  endfunction

endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      hold_q <= meta_q;
    end
  end

  assign q_sync = hold_q;
endmodule

// File: rtl/swap_consensus.sv
module swap_consensus
  import swap_sync_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_req,
  input  logic [CNT_W-1:0] cyc_to_dec,
  input  logic [CNT_W-1:0] win_len,
  input  logic             dec_pulse,
  input  logic             line_s,
  output logic             rdy_out,
  output logic             grant
);
  logic rdy_q;
  logic parked_q;
  logic grant_q;
  logic blocked;

  assign blocked = (cyc_to_dec < win_len) || dec_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q    <= 1'b0;
      parked_q <= 1'b0;
      grant_q  <= 1'b0;
    end else begin
      grant_q <= 1'b0;
      if (dec_pulse && rdy_q && line_s) begin
        grant_q <= 1'b1;
        rdy_q   <= 1'b0;
      end
      if (blocked) begin
        if (swap_req && !rdy_q) parked_q <= 1'b1;
      end else if (swap_req || parked_q) begin
        rdy_q    <= 1'b1;
        parked_q <= 1'b0;
      end
    end
  end

  assign rdy_out = rdy_q;
  assign grant   = grant_q;
endmodule

// File: rtl/chan_param_slot.sv
module chan_param_slot #(
  parameter int MAG_W = 8,
  parameter int VRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [MAG_W-1:0] wr_mag,
  input  logic [VRQ_W-1:0] wr_vreq,
  input  logic             grant,
  input  logic             vblank,
  output logic             swap_evt,
  output logic [MAG_W-1:0] act_mag,
  output logic [VRQ_W-1:0] act_vreq
);
  logic [MAG_W-1:0] stg_mag_q,  act_mag_q;
  logic [VRQ_W-1:0] stg_vreq_q, act_vreq_q;
  logic             due_q, pend_q, swap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_mag_q  <= '0;
      stg_vreq_q <= '0;
      act_mag_q  <= '0;
      act_vreq_q <= '0;
      due_q      <= 1'b0;
      pend_q     <= 1'b0;
      swap_q     <= 1'b0;
    end else begin
      swap_q <= 1'b0;
      if (vblank && due_q) begin
        swap_q <= 1'b1;
        due_q  <= 1'b0;
        if (pend_q) begin
          act_mag_q  <= stg_mag_q;
          act_vreq_q <= stg_vreq_q;
          pend_q     <= 1'b0;
        end
      end
      if (grant) due_q <= 1'b1;
      if (wr_en) begin
        stg_mag_q  <= wr_mag;
        stg_vreq_q <= wr_vreq;
        pend_q     <= 1'b1;
      end
    end
  end

  assign swap_evt = swap_q;
  assign act_mag  = act_mag_q;
  assign act_vreq = act_vreq_q;
endmodule

// File: rtl/swap_lockstep_ctrl.sv
module swap_lockstep_ctrl
  import swap_sync_pkg::*;
#(
  parameter int NCH   = DEF_NCH,
  parameter int CNT_W = DEF_CNT_W,
  parameter int MAG_W = DEF_MAG_W,
  parameter int VRQ_W = DEF_VRQ_W,
  localparam int ID_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 swap_req,
  input  logic [CNT_W-1:0]     cyc_to_dec,
  input  logic [CNT_W-1:0]     win_len,
  input  logic                 dec_pulse,
  output logic                 rdy_release,
  input  logic                 line_in,
  output logic                 swap_grant,
  input  logic                 wr_en,
  input  logic [ID_W-1:0]      wr_id,
  input  logic [MAG_W-1:0]     wr_mag,
  input  logic [VRQ_W-1:0]     wr_vreq,
  input  logic [NCH-1:0]       chan_vblank,
  output logic [NCH-1:0]       chan_swap,
  output logic [NCH*MAG_W-1:0] act_mag,
  output logic [NCH*VRQ_W-1:0] act_vreq
);
  logic line_s;
  logic grant_w;

  sync_2ff #(.RST_VAL(1'b0)) u_line_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (line_in),
    .q_sync  (line_s)
  );

  swap_consensus #(.CNT_W(CNT_W)) u_consensus (
    .clk        (clk),
    .rst        (rst),
    .swap_req   (swap_req),
    .cyc_to_dec (cyc_to_dec),
    .win_len    (win_len),
    .dec_pulse  (dec_pulse),
    .line_s     (line_s),
    .rdy_out    (rdy_release),
    .grant      (grant_w)
  );

  assign swap_grant = grant_w;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel_wr;
    assign sel_wr = wr_en && (wr_id == ID_W'(i));

    chan_param_slot #(.MAG_W(MAG_W), .VRQ_W(VRQ_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (sel_wr),
      .wr_mag   (wr_mag),
      .wr_vreq  (wr_vreq),
      .grant    (grant_w),
      .vblank   (chan_vblank[i]),
      .swap_evt (chan_swap[i]),
      .act_mag  (act_mag[i*MAG_W +: MAG_W]),
      .act_vreq (act_vreq[i*VRQ_W +: VRQ_W])
    );
  end
endmodule

// File: rtl/swap_lockstep_chk.sv
module swap_lockstep_chk #(
  parameter int NCH   = 8,
  parameter int CNT_W = 12,
  parameter int MAG_W = 8,
  parameter int VRQ_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CNT_W-1:0]     cyc_to_dec,
  input logic [CNT_W-1:0]     win_len,
  input logic                 dec_pulse,
  input logic                 rdy_release,
  input logic                 swap_grant,
  input logic [NCH-1:0]       chan_vblank,
  input logic [NCH-1:0]       chan_swap,
  input logic [NCH*MAG_W-1:0] act_mag,
  input logic [NCH*VRQ_W-1:0] act_vreq
);
  AST_GRANT_AT_DECISION: assert property (@(posedge clk) disable iff (rst)
    swap_grant |-> $past(dec_pulse)); // R7
  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    swap_grant |=> !swap_grant); // R7
  AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    swap_grant |-> $past(rdy_release)); // R4
  AST_RELEASE_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    swap_grant |-> !rdy_release); // R6
  AST_NO_RISE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_release) |-> ($past(cyc_to_dec) >= $past(win_len)) && !$past(dec_pulse)); // R3
  AST_SWAP_ON_OWN_BLANK: assert property (@(posedge clk) disable iff (rst)
    (|chan_swap) |-> ((chan_swap & ~$past(chan_vblank)) == '0)); // R9
  AST_ACTIVE_ONLY_AT_SWAP: assert property (@(posedge clk) disable iff (rst)
    ((act_mag != $past(act_mag)) || (act_vreq != $past(act_vreq))) |-> (|chan_swap)); // R8
endmodule

bind swap_lockstep_ctrl swap_lockstep_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .MAG_W(MAG_W), .VRQ_W(VRQ_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cyc_to_dec  (cyc_to_dec),
  .win_len     (win_len),
  .dec_pulse   (dec_pulse),
  .rdy_release (rdy_release),
  .swap_grant  (swap_grant),
  .chan_vblank (chan_vblank),
  .chan_swap   (chan_swap),
  .act_mag     (act_mag),
  .act_vreq    (act_vreq)
);

// File: tb/test_swap_lockstep_ctrl.sv
module test_swap_lockstep_ctrl;
  localparam int CLK_P = 10;
  localparam int NCH = 8, CNT_W = 12, MAG_W = 8, VRQ_W = 8, ID_W = 3;
  localparam int FL = 20;
  localparam int WIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swap_req = 1'b0;
  logic [CNT_W-1:0] cyc_to_dec = CNT_W'(FL);
  logic [CNT_W-1:0] win_len = CNT_W'(WIN);
  logic dec_pulse = 1'b0;
  logic rdy_release, swap_grant, line_in;
  logic others_rdy = 1'b1;
  logic wr_en = 1'b0;
  logic [ID_W-1:0] wr_id = '0;
  logic [MAG_W-1:0] wr_mag = '0;
  logic [VRQ_W-1:0] wr_vreq = '0;
  logic [NCH-1:0] chan_vblank = '0;
  logic [NCH-1:0] chan_swap;
  logic [NCH*MAG_W-1:0] act_mag;
  logic [NCH*VRQ_W-1:0] act_vreq;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  logic dec_d = 1'b0;

  assign line_in = rdy_release & others_rdy;

  always #(CLK_P/2) clk = ~clk;

  swap_lockstep_ctrl #(.NCH(NCH), .CNT_W(CNT_W), .MAG_W(MAG_W), .VRQ_W(VRQ_W)) i_swap_lockstep_ctrl (
    .clk(clk), .rst(rst), .swap_req(swap_req), .cyc_to_dec(cyc_to_dec), .win_len(win_len),
    .dec_pulse(dec_pulse), .rdy_release(rdy_release), .line_in(line_in), .swap_grant(swap_grant),
    .wr_en(wr_en), .wr_id(wr_id), .wr_mag(wr_mag), .wr_vreq(wr_vreq), .chan_vblank(chan_vblank),
    .chan_swap(chan_swap), .act_mag(act_mag), .act_vreq(act_vreq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares grants against the scoreboard queue
  always @(posedge clk) dec_d <= dec_pulse;
  always @(negedge clk) begin
    if (!rst) begin
      if (dec_d) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: actual grant %0b expected none queued", swap_grant);
        end else begin
          chk("R4/R5 grant at decision", 32'(swap_grant), 32'(exp_q.pop_front()));
        end
      end else if (swap_grant) begin
        checks++; errors++;
        $display("FAIL R7: actual grant 1 expected 0 outside decision");
      end
    end
  end

  // driver: one frame counting down to a decision point
  task automatic frame(input int req_at, input bit others, input bit exp_grant,
                       input bit rdy_after_req, input string req_tag);
    others_rdy = others;
    exp_q.push_back(exp_grant);
    for (int k = FL - 1; k >= 0; k--) begin
      @(negedge clk);
      if (k + 1 == req_at) chk(req_tag, 32'(rdy_release), 32'(rdy_after_req));
      cyc_to_dec = CNT_W'(k);
      dec_pulse  = (k == 0);
      swap_req   = (k == req_at);
    end
    @(negedge clk);
    dec_pulse  = 1'b0;
    swap_req   = 1'b0;
    cyc_to_dec = CNT_W'(FL);
  endtask

  task automatic blank(input logic [NCH-1:0] v);
    @(negedge clk);
    chan_vblank = v;
    @(negedge clk);
    chan_vblank = '0;
  endtask

  task automatic write_ch(input int c, input logic [7:0] m, input logic [7:0] r);
    @(negedge clk);
    wr_en = 1'b1; wr_id = ID_W'(c); wr_mag = m; wr_vreq = r;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] act_of(input int c);
    return {act_mag[c*MAG_W +: MAG_W], act_vreq[c*VRQ_W +: VRQ_W]};
  endfunction

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grant", 32'(swap_grant), 0);
    chk("R1 release", 32'(rdy_release), 0);
    chk("R1 chan_swap", 32'(chan_swap), 0);
    chk("R1 act_mag", 32'(act_mag[31:0]) | 32'(act_mag[63:32]), 0);
    chk("R1 act_vreq", 32'(act_vreq[31:0]) | 32'(act_vreq[63:32]), 0);

    frame(10, 1'b1, 1'b1, 1'b1, "R2 ready after request");
    chk("R6 released after grant", 32'(rdy_release), 0);
    frame(10, 1'b0, 1'b0, 1'b1, "R2 ready before blocked decision");
    chk("R5 ready held", 32'(rdy_release), 1);
    frame(-1, 1'b1, 1'b1, 1'b0, "R5 retry");
    frame(2, 1'b1, 1'b0, 1'b0, "R3 blocked in window");
    @(negedge clk);
    chk("R3 parked request applied", 32'(rdy_release), 1);
    frame(-1, 1'b1, 1'b1, 1'b0, "R3 deferred grant");
    win_len = '0;
    frame(3, 1'b1, 1'b1, 1'b1, "R13 no window");
    win_len = CNT_W'(WIN);

    // consume due swaps left from the grants above
    @(negedge clk); chan_vblank = '1;
    @(negedge clk); chan_vblank = '0;
    chk("R11 swap with nothing staged", 32'(chan_swap), 32'hFF);
    chk("R11 active unchanged", 32'(act_of(2)), 0);

    write_ch(2, 8'h15, 8'h3A);
    chk("R8 staged not active", 32'(act_of(2)), 0);
    @(negedge clk); chan_vblank = 8'h04;
    @(negedge clk); chan_vblank = '0;
    chk("R10 no swap without grant", 32'(chan_swap), 0);
    chk("R10 overrun keeps old values", 32'(act_of(2)), 0);

    frame(10, 1'b1, 1'b1, 1'b1, "R2 request");
    @(negedge clk); chan_vblank = 8'h24;
    @(negedge clk); chan_vblank = '0;
    chk("R9 swap pulses", 32'(chan_swap), 32'h24);
    chk("R9 staged become active", 32'(act_of(2)), 32'h153A);
    chk("R11 other channel keeps values", 32'(act_of(5)), 0);
    @(negedge clk);
    chk("R9 one-cycle swap pulse", 32'(chan_swap), 0);
    blank(8'h04);
    chk("R10 swap consumed", 32'(chan_swap), 0);

    write_ch(2, 8'h07, 8'h11);
    frame(10, 1'b1, 1'b1, 1'b1, "R2 request");
    @(negedge clk);
    chan_vblank = 8'h04; wr_en = 1'b1; wr_id = 3'd2; wr_mag = 8'h09; wr_vreq = 8'h22;
    @(negedge clk);
    chan_vblank = '0; wr_en = 1'b0;
    chk("R12 old staged wins", 32'(act_of(2)), 32'h0711);
    frame(10, 1'b1, 1'b1, 1'b1, "R2 request");
    blank(8'h04);
    chk("R12 new write applied next swap", 32'(act_of(2)), 32'h0922);

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule